// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. An instruction fetch, a register read, an ALU operation, an optional data-memory access and the register write-back all happen inside one cycle. It implements seven register-to-register operations: add, subtract, and, or, xor, nor and signed set-less-than. It also implements word load, word store, branch-if-equal and an absolute jump. The program counter, the 32-entry register file, the sign extender, the next-PC adders and both memories are inside the module. Instruction memory and data memory are separate arrays, so a fetch and a data access never compete in a cycle.

A loader port fills either memory one word per clock. A testbench or boot agent normally uses it while reset is held. A combinational debug port reads any register, and the current PC is driven out. There is no handshake of any kind; the core simply runs whenever reset is low.

The decoder sorts every opcode into one of six instruction classes: CLS_RTYPE, CLS_LOAD, CLS_STORE, CLS_BRANCH, CLS_JUMP and CLS_NOP. The class drives the control word. The ALU function is then chosen in a second step. A 2-bit ALU mode selects a forced add, a forced subtract, or decoding of the funct field. The next PC takes one of three transitions: jump, which always wins; branch-taken, when the class is branch and the ALU result is zero; and sequential, otherwise. The PC is reset to 0 synchronously.

Top module: `onecycle_cpu`

## Requirements
- R1: While `rst` is high, the PC and all 32 registers are cleared on each clock, and no register or data-memory write is made by instructions. One clock after `rst` is asserted, `pc_out` reads 0.
- R2: The core fetches the instruction word at address `pc_out[9:2]`. After each non-control instruction, `pc_out` advances by 4. `pc_out[1:0]` is always 0.
- R3: Register operations use opcode 000000 and take their fields from rs = bits 25-21, rt = bits 20-16 and rd = bits 15-11. The funct field is bits 5-0. The funct codes are 100000 add, 100010 subtract (rs-rt), 100100 and, 100101 or, 100110 xor, 100111 nor, and 101010 signed set-less-than (rs<rt gives 1, else 0). The result is written to rd at the clock edge.
- R4: Load (opcode 100011) writes the data word at `(rs + sign-extended bits 15-0)[9:2]` into rt in the same cycle. Negative offsets are allowed.
- R5: Store (opcode 101011) writes rt to the data word at `(rs + sign-extended offset)[9:2]` and writes no register.
- R6: Branch-if-equal (opcode 000100) compares rs and rt by subtraction. If they are equal, the next PC is PC+4 plus the sign-extended offset shifted left by 2; otherwise it is PC+4. A branch writes nothing.
- R7: Jump (opcode 000010) sets the next PC to {(PC+4)[31:28], bits 25-0, 2'b00} and writes nothing.
- R8: Register 0 always reads 0, and writes to it are discarded.
- R9: Any other opcode, and a register operation with an unlisted funct code, behaves as a no-op that only advances the PC by 4.
- R10: With `ld_en` high, `ld_data` is written at the clock edge to word `ld_addr` of data memory when `ld_dmem` is 1, or of instruction memory when it is 0. A loader write takes priority over a store to the same memory.
- R11: `dbg_data` shows register `dbg_sel` combinationally, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Loader write enable |
| ld_dmem | input | 1 | Loader target: 1 data memory, 0 instruction memory |
| ld_addr | input | MAW (8) | Loader word address |
| ld_data | input | 32 | Loader write data |
| dbg_sel | input | 5 | Debug register index |
| dbg_data | output | 32 | Debug register value |
| pc_out | output | 32 | Current program counter |

## Verification
The bench builds the core with the default 256-word memories. With that size, a hand-written program can reach every opcode and funct code, a forward branch that skips code, a branch that is not taken, a branch back onto itself, a jump, and a load with a negative offset. Because the PC never leaves the low kilobyte, the upper nibble kept by a jump is always zero in the directed program. The bound checker compares the jump target, including that nibble, on every jump. A reload while reset is held shows the loader writing both memories and the register clear taking effect.

// File: rtl/onecycle_pkg.sv
package onecycle_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RAW   = $clog2(NREGS);

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JMP   = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_XOR = 6'b100110;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_XOR = 4'b0010,
        ALU_NOR = 4'b0011,
        ALU_ADD = 4'b0110,
        ALU_SUB = 4'b1110,
        ALU_SLT = 4'b1111
    } alu_fn_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_mode_e;

    typedef enum logic [2:0] {
        CLS_NOP,
        CLS_RTYPE,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP
    } instr_cls_e;

    typedef struct packed {
        logic      reg_dst;
        logic      alu_src;
        logic      mem_to_reg;
        logic      reg_write;
        logic      mem_read;
        logic      mem_write;
        logic      branch;
        logic      jump;
        alu_mode_e alu_mode;
    } ctrl_t;

endpackage

// File: rtl/oc_decode.sv
module oc_decode
    import onecycle_pkg::*;
(
    input  logic [5:0]  opcode,
    output instr_cls_e  cls,
    output ctrl_t       ctrl
);

    always_comb begin
        unique case (opcode)
            OPC_REG:   cls = CLS_RTYPE;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BRANCH;
            OPC_JMP:   cls = CLS_JUMP;
            default:   cls = CLS_NOP;
        endcase
    end

    always_comb begin
        ctrl = '0;
        ctrl.alu_mode = AOP_ADD;
        unique case (cls)
            CLS_RTYPE: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_mode  = AOP_FUNCT;
            end
            CLS_LOAD: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            CLS_STORE: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            CLS_BRANCH: begin
                ctrl.branch   = 1'b1;
                ctrl.alu_mode = AOP_SUB;
            end
            CLS_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: begin
                ctrl.alu_mode = AOP_ADD;
            end
        endcase
    end

endmodule

// File: rtl/oc_aluctl.sv
module oc_aluctl
    import onecycle_pkg::*;
(
    input  alu_mode_e  mode,
    input  logic [5:0] funct,
    output alu_fn_e    fn,
    output logic       fn_ok
);

    always_comb begin
        fn    = ALU_ADD;
        fn_ok = 1'b1;
        unique case (mode)
            AOP_ADD: fn = ALU_ADD;
            AOP_SUB: fn = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_XOR:  fn = ALU_XOR;
                    FN_NOR:  fn = ALU_NOR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/oc_regfile.sv
module oc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra_dbg,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd_dbg
);

    logic [W-1:0] rf [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
        end else if (we && (waddr != '0)) begin
            rf[waddr] <= wdata;
        end
    end

    assign rd1    = (ra1    == '0) ? '0 : rf[ra1];
    assign rd2    = (ra2    == '0) ? '0 : rf[ra2];
    assign rd_dbg = (ra_dbg == '0) ? '0 : rf[ra_dbg];

endmodule

// File: rtl/oc_wordmem.sv
module oc_wordmem #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [W-1:0]  ld_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/onecycle_cpu.sv
module onecycle_cpu
    import onecycle_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int MAW      = $clog2(MEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic            ld_dmem,
    input  logic [MAW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [RAW-1:0]  dbg_sel,
    output logic [XLEN-1:0] dbg_data,
    output logic [XLEN-1:0] pc_out
);

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
    logic [XLEN-1:0] instr, simm, rd1, rd2, alu_b, alu_y, dm_rdata, wb_data;
    logic [5:0]      opcode, funct;
    logic [RAW-1:0]  f_rs, f_rt, f_rd, wb_addr;
    logic [15:0]     imm16;
    logic [25:0]     jidx;
    instr_cls_e      cls;
    ctrl_t           ctrl;
    alu_fn_e         fn;
    logic            fn_ok, alu_zero, take_br, rf_we, dm_we;

    assign opcode = instr[31:26];
    assign f_rs   = instr[25:21];
    assign f_rt   = instr[20:16];
    assign f_rd   = instr[15:11];
    assign funct  = instr[5:0];
    assign imm16  = instr[15:0];
    assign jidx   = instr[25:0];

    oc_wordmem #(.DEPTH(MEM_WORDS), .W(XLEN)) u_imem (
        .clk     (clk),
        .ld_we   (ld_en & ~ld_dmem),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .we      (1'b0),
        .waddr   ('0),
        .wdata   ('0),
        .raddr   (pc_q[MAW+1:2]),
        .rdata   (instr)
    );

    oc_decode u_dec (
        .opcode (opcode),
        .cls    (cls),
        .ctrl   (ctrl)
    );

    oc_aluctl u_actl (
        .mode  (ctrl.alu_mode),
        .funct (funct),
        .fn    (fn),
        .fn_ok (fn_ok)
    );

    assign wb_addr = ctrl.reg_dst ? f_rd : f_rt;
    assign rf_we   = ctrl.reg_write & fn_ok & ~rst;

    oc_regfile #(.NREG(NREGS), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .waddr  (wb_addr),
        .wdata  (wb_data),
        .ra1    (f_rs),
        .ra2    (f_rt),
        .ra_dbg (dbg_sel),
        .rd1    (rd1),
        .rd2    (rd2),
        .rd_dbg (dbg_data)
    );

    assign simm  = {{(XLEN-16){imm16[15]}}, imm16};
    assign alu_b = ctrl.alu_src ? simm : rd2;

    always_comb begin
        unique case (fn)
            ALU_ADD: alu_y = rd1 + alu_b;
            ALU_SUB: alu_y = rd1 - alu_b;
            ALU_AND: alu_y = rd1 & alu_b;
            ALU_OR:  alu_y = rd1 | alu_b;
            ALU_XOR: alu_y = rd1 ^ alu_b;
            ALU_NOR: alu_y = ~(rd1 | alu_b);
            ALU_SLT: alu_y = {{(XLEN-1){1'b0}}, $signed(rd1) < $signed(alu_b)};
            default: alu_y = '0;
        endcase
    end

    assign alu_zero = (alu_y == '0);
    assign dm_we    = ctrl.mem_write & ~rst;

    oc_wordmem #(.DEPTH(MEM_WORDS), .W(XLEN)) u_dmem (
        .clk     (clk),
        .ld_we   (ld_en & ld_dmem),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .we      (dm_we),
        .waddr   (alu_y[MAW+1:2]),
        .wdata   (rd2),
        .raddr   (alu_y[MAW+1:2]),
        .rdata   (dm_rdata)
    );

    assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

    assign pc_plus4 = pc_q + 32'd4;
    assign br_tgt   = pc_plus4 + {simm[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {pc_plus4[31:28], jidx, 2'b00};
    assign take_br  = ctrl.branch & alu_zero;

    always_comb begin
        if (ctrl.jump)      pc_next = jmp_tgt;
        else if (take_br)   pc_next = br_tgt;
        else                pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_out = pc_q;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], alu_y[XLEN-1:MAW+2], alu_y[1:0], ctrl.mem_read};

endmodule

// File: rtl/oc_checker.sv
module oc_checker
    import onecycle_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input instr_cls_e      cls,
    input logic            take_br,
    input logic            rf_we,
    input logic            dm_we,
    input logic [RAW-1:0]  dbg_sel,
    input logic [XLEN-1:0] dbg_data
);

    logic [XLEN-1:0] chk_p4, chk_boff, chk_jt;
    assign chk_p4   = pc + 32'd4;
    assign chk_boff = {{14{instr[15]}}, instr[15:0], 2'b00};
    assign chk_jt   = {chk_p4[31:28], instr[25:0], 2'b00};

    assert_pc_cleared_R1: assert property (@(posedge clk)
        rst |=> (pc == '0));

    assert_no_write_in_reset_R1: assert property (@(posedge clk)
        rst |-> (!rf_we && !dm_we));

    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_RTYPE || cls == CLS_LOAD || cls == CLS_STORE || cls == CLS_NOP)
        |=> (pc == $past(pc) + 32'd4));

    assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_STORE) |-> !rf_we);

    assert_branch_target_R6: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_BRANCH && take_br) |=> (pc == $past(chk_p4) + $past(chk_boff)));

    assert_branch_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_BRANCH) |-> (!rf_we && !dm_we));

    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_JUMP) |=> (pc == $past(chk_jt)));

    assert_r0_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == '0) |-> (dbg_data == '0));

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (cls == CLS_NOP) |-> (!rf_we && !dm_we));

endmodule

bind onecycle_cpu oc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc       (pc_q),
    .instr    (instr),
    .cls      (cls),
    .take_br  (take_br),
    .rf_we    (rf_we),
    .dm_we    (dm_we),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
);

// File: tb/onecycle_cpu_tb.sv
module onecycle_cpu_tb;

    localparam int MW  = 256;
    localparam int MAW = $clog2(MW);

    localparam logic [5:0] T_LW  = 6'b100011;
    localparam logic [5:0] T_SW  = 6'b101011;
    localparam logic [5:0] T_BEQ = 6'b000100;
    localparam logic [5:0] T_J   = 6'b000010;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ld_en = 1'b0, ld_dmem = 1'b0;
    logic [MAW-1:0]  ld_addr = '0;
    logic [31:0]     ld_data = '0;
    logic [4:0]      dbg_sel = '0;
    logic [31:0]     dbg_data, pc_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    onecycle_cpu u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .dbg_sel(dbg_sel), .dbg_data(dbg_data), .pc_out(pc_out)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] idx);
        return {T_J, idx};
    endfunction

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %08h expected %08h", what, got, exp);
        end
    endtask

    task automatic load_word(input logic to_dmem, input int addr, input logic [31:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = to_dmem; ld_addr = addr[MAW-1:0]; ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
        dbg_sel = r;
        #0.5;
        v = dbg_data;
    endtask

    // Execution trace: {pc after the step, register to read, its value}.
    // Steps 1-3 R4, 4-11 R3, 12 R8, 13 R5, 14 R4/R5, 15 R4 negative offset,
    // 16 R6 taken, 17 R6 not taken, 18 R9 opcode, 19 R9 funct, 20 R7, 21-22 R6 self-loop.
    localparam logic [68:0] TRACE [0:21] = '{
        {32'h04, 5'd1,  32'h0000_0007},
        {32'h08, 5'd2,  32'hFFFF_FFF0},
        {32'h0C, 5'd3,  32'h1234_5678},
        {32'h10, 5'd4,  32'hFFFF_FFF7},
        {32'h14, 5'd5,  32'h0000_0017},
        {32'h18, 5'd6,  32'h1234_5670},
        {32'h1C, 5'd7,  32'h1234_567F},
        {32'h20, 5'd8,  32'hEDCB_A988},
        {32'h24, 5'd9,  32'hFFFF_FFF8},
        {32'h28, 5'd10, 32'h0000_0001},
        {32'h2C, 5'd11, 32'h0000_0000},
        {32'h30, 5'd0,  32'h0000_0000},
        {32'h34, 5'd4,  32'hFFFF_FFF7},
        {32'h38, 5'd12, 32'hFFFF_FFF7},
        {32'h3C, 5'd13, 32'h1234_5678},
        {32'h48, 5'd14, 32'h0000_0000},
        {32'h4C, 5'd14, 32'h0000_0000},
        {32'h50, 5'd14, 32'h0000_0000},
        {32'h54, 5'd15, 32'h0000_0000},
        {32'h60, 5'd15, 32'h0000_0000},
        {32'h60, 5'd1,  32'h0000_0007},
        {32'h60, 5'd1,  32'h0000_0007}
    };

    logic [31:0] prog [MW];

    initial begin
        logic [31:0] v;
        for (int i = 0; i < MW; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(T_LW, 5'd0, 5'd1, 16'd0);
        prog[1]  = enc_i(T_LW, 5'd0, 5'd2, 16'd4);
        prog[2]  = enc_i(T_LW, 5'd0, 5'd3, 16'd8);
        prog[3]  = enc_r(5'd1, 5'd2, 5'd4,  6'b100000);
        prog[4]  = enc_r(5'd1, 5'd2, 5'd5,  6'b100010);
        prog[5]  = enc_r(5'd3, 5'd2, 5'd6,  6'b100100);
        prog[6]  = enc_r(5'd1, 5'd3, 5'd7,  6'b100101);
        prog[7]  = enc_r(5'd3, 5'd2, 5'd8,  6'b100110);
        prog[8]  = enc_r(5'd1, 5'd0, 5'd9,  6'b100111);
        prog[9]  = enc_r(5'd2, 5'd1, 5'd10, 6'b101010);
        prog[10] = enc_r(5'd1, 5'd2, 5'd11, 6'b101010);
        prog[11] = enc_r(5'd1, 5'd1, 5'd0,  6'b100000);
        prog[12] = enc_i(T_SW, 5'd0, 5'd4, 16'd12);
        prog[13] = enc_i(T_LW, 5'd0, 5'd12, 16'd12);
        prog[14] = enc_i(T_LW, 5'd5, 5'd13, 16'hFFF1);
        prog[15] = enc_i(T_BEQ, 5'd3, 5'd13, 16'd2);
        prog[16] = enc_r(5'd1, 5'd1, 5'd14, 6'b100000);
        prog[17] = enc_r(5'd1, 5'd1, 5'd14, 6'b100000);
        prog[18] = enc_i(T_BEQ, 5'd1, 5'd2, 16'd5);
        prog[19] = {6'b111111, 5'd1, 5'd14, 16'h0001};
        prog[20] = enc_r(5'd1, 5'd1, 5'd15, 6'b000001);
        prog[21] = enc_j(26'h18);
        prog[22] = enc_r(5'd1, 5'd1, 5'd15, 6'b100000);
        prog[23] = enc_r(5'd1, 5'd1, 5'd15, 6'b100000);
        prog[24] = enc_i(T_BEQ, 5'd0, 5'd0, 16'hFFFF);

        // R10: fill both memories while reset is held
        for (int i = 0; i < MW; i++) load_word(1'b0, i, prog[i]);
        load_word(1'b1, 0, 32'h0000_0007);
        load_word(1'b1, 1, 32'hFFFF_FFF0);
        load_word(1'b1, 2, 32'h1234_5678);
        load_word(1'b1, 3, 32'h0000_0000);

        // R1: reset state
        check("R1 pc in reset", pc_out, 32'h0);
        read_reg(5'd1, v);
        check("R1 r1 cleared in reset", v, 32'h0);

        @(negedge clk);
        rst = 1'b0;
        for (int s = 0; s < 22; s++) begin
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2 trace step %0d pc", s + 1), pc_out, TRACE[s][68:37]);
            read_reg(TRACE[s][36:32], v);
            check($sformatf("R3 trace step %0d reg %0d", s + 1, TRACE[s][36:32]), v, TRACE[s][31:0]);
        end

        // R11: debug port follows dbg_sel without a clock
        read_reg(5'd3, v);
        check("R11 dbg r3", v, 32'h1234_5678);
        read_reg(5'd0, v);
        check("R8 dbg r0", v, 32'h0);

        // R1: reassert reset, registers cleared, instruction at 0 not written back
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 pc after reset", pc_out, 32'h0);
        read_reg(5'd3, v);
        check("R1 r3 cleared", v, 32'h0);
        @(posedge clk);
        @(negedge clk);
        read_reg(5'd1, v);
        check("R1 no writeback in reset", v, 32'h0);

        // R10: new data word and instruction through the loader, then run
        load_word(1'b1, 5, 32'hCAFE_F00D);
        load_word(1'b0, 0, enc_i(T_LW, 5'd0, 5'd20, 16'd20));
        check("R1 pc held during load", pc_out, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 pc after reloaded lw", pc_out, 32'h4);
        read_reg(5'd20, v);
        check("R10 r20 from loaded dmem", v, 32'hCAFE_F00D);

        // R7: reloaded jump at address 0
        @(negedge clk);
        rst = 1'b1;
        load_word(1'b0, 0, enc_j(26'h0A));
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 jump to 0x28", pc_out, 32'h28);
        @(posedge clk);
        @(negedge clk);
        check("R2 step after jump", pc_out, 32'h2C);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule